// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit forms the memory address for a single-register load or store and the value that the base register takes once the access is over. The base comes from a small internal register file. The offset is either a 12-bit immediate magnitude or a second register from the same file, shifted by a 5-bit amount. An up/down control picks addition or subtraction. Three indexing modes decide which sum drives the bus and whether the base register is rewritten.

A request is accepted only while the unit is idle. The address, writeback enable and writeback value are registered and held until the memory side pulses the access-complete strobe. The writeback is committed to the register file on that edge. A host write port loads register contents, and a read port exposes them, so that every writeback can be observed from outside.

Top module: `agu_top`

## Requirements
- R1: After reset `addr_valid_o` is 0 and every register reads 0 on `rd_data_o`.
- R2: With `use_reg_i`=0 the offset is `imm_i` (0..4095) zero-extended. `up_i`=1 adds it to the base and `up_i`=0 subtracts it.
- R3: With `mode_i`=0 (offset), `addr_o` is base plus or minus the offset and `wb_en_o` is 0, so the base register is unchanged after completion. `mode_i`=3 behaves exactly as 0.
- R4: With `mode_i`=1 (pre-indexed), `addr_o` is base plus or minus the offset. `wb_en_o` is 1, `wb_val_o` equals `addr_o`, and the base register holds that address after completion.
- R5: With `mode_i`=2 (post-indexed), `addr_o` is the unmodified base. `wb_en_o` is 1, `wb_val_o` is base plus or minus the offset, and the base register holds `wb_val_o` after completion.
- R6: With `use_reg_i`=1 the offset is register `off_sel_i` shifted by `shamt_i` (0..31). `shtype_i`=0 is a logical left shift, 1 is a logical right shift with zero fill, 2 is an arithmetic right shift replicating bit 31, and 3 acts as 0.
- R7: A request sampled on a rising edge with `addr_valid_o`=0 drives `addr_valid_o`, `addr_o`, `wb_en_o` and `wb_val_o` from that edge on. The writeback is committed on the edge where `done_i` is sampled high with `addr_valid_o`=1, and `addr_valid_o` falls on that same edge. Before that edge `rd_data_o` still returns the old base.
- R8: While `addr_valid_o`=1, a new `req_i` is ignored and the outputs stay stable until completion.
- R9: Address and writeback arithmetic is modulo 2^32 and wraps silently.
- R10: A host write (`wr_en_i`) loads `wr_data_i` into register `wr_idx_i`, and it is visible on `rd_data_o` after the next edge. If a commit targets the same register on the same edge, the commit wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Issue a transfer |
| base_sel_i | input | 3 | Base register index |
| off_sel_i | input | 3 | Offset register index |
| mode_i | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 as 0 |
| use_reg_i | input | 1 | 1: register offset, 0: immediate |
| up_i | input | 1 | 1 add offset, 0 subtract |
| imm_i | input | 12 | Immediate magnitude |
| shamt_i | input | 5 | Shift amount for register offset |
| shtype_i | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 as LSL |
| done_i | input | 1 | Access-complete strobe |
| wr_en_i | input | 1 | Host register write enable |
| wr_idx_i | input | 3 | Host write index |
| wr_data_i | input | 32 | Host write data |
| rd_idx_i | input | 3 | Read port index |
| rd_data_o | output | 32 | Read port data |
| addr_valid_o | output | 1 | Access outstanding |
| addr_o | output | 32 | Access address |
| wb_en_o | output | 1 | Base writeback pending |
| wb_val_o | output | 32 | Base writeback value |

## Verification
The assertions assume that `done_i` carries meaning only while an access is outstanding, and that the host does not write the register being committed on the same edge. The bench raises `done_i` only after it has seen `addr_valid_o` high. It keeps host writes in idle windows, and it keeps base and offset indices apart, so that a pre- or post-indexed commit never overwrites an offset that is still being checked. Shift types, modes, signs and shift amounts are swept together with offset values whose top bit is set and clear.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {IDX_OFF = 2'd0, IDX_PRE = 2'd1, IDX_POST = 2'd2, IDX_RSV = 2'd3} idx_mode_e;
  typedef enum logic [1:0] {SH_LSL = 2'd0, SH_LSR = 2'd1, SH_ASR = 2'd2, SH_RSV = 2'd3} sh_kind_e;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5
) (
  input  logic             use_reg_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [DW-1:0]    reg_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [1:0]       shtype_i,
  output logic [DW-1:0]    off_o
);
  import agu_pkg::*;
  logic [DW-1:0] sh;

  always_comb begin
    case (sh_kind_e'(shtype_i))
      SH_LSR:  sh = reg_i >> shamt_i;
      SH_ASR:  sh = DW'($signed(reg_i) >>> shamt_i);
      default: sh = reg_i << shamt_i;
    endcase
    off_o = use_reg_i ? sh : {{(DW-IMM_W){1'b0}}, imm_i};
  end

  // R6: fill of vacated top bit
  always_comb begin
    if (use_reg_i && shtype_i == SH_LSR && shamt_i != '0)
      assert_lsr_fill_R6: assert (off_o[DW-1] == 1'b0);
    if (use_reg_i && shtype_i == SH_ASR)
      assert_asr_sign_R6: assert (off_o[DW-1] == reg_i[DW-1]);
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] off_i,
  input  logic          up_i,
  input  logic [1:0]    mode_i,
  output logic [DW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [DW-1:0] wb_val_o
);
  import agu_pkg::*;
  logic [DW-1:0] sum;

  always_comb begin
    sum      = up_i ? base_i + off_i : base_i - off_i;  // modulo 2^DW
    addr_o   = (mode_i == IDX_POST) ? base_i : sum;
    wb_en_o  = (mode_i == IDX_PRE) || (mode_i == IDX_POST);
    wb_val_o = sum;
  end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cm_en_i,
  input  logic [RW-1:0] cm_idx_i,
  input  logic [DW-1:0] cm_data_i,
  input  logic          wr_en_i,
  input  logic [RW-1:0] wr_idx_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [RW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [RW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o,
  input  logic [RW-1:0] rc_idx_i,
  output logic [DW-1:0] rc_data_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (cm_en_i && cm_idx_i == RW'(g))        regs_q[g] <= cm_data_i;  // commit wins
      else if (wr_en_i && wr_idx_i == RW'(g))        regs_q[g] <= wr_data_i;
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];
  assign rc_data_o = regs_q[rc_idx_i];

  assert_commit_lands_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_en_i |=> regs_q[$past(cm_idx_i)] == $past(cm_data_i));
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int NREG  = 8,
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  parameter int SH_W  = 5,
  localparam int RW   = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [RW-1:0]    base_sel_i,
  input  logic [RW-1:0]    off_sel_i,
  input  logic [1:0]       mode_i,
  input  logic             use_reg_i,
  input  logic             up_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [1:0]       shtype_i,
  input  logic             done_i,
  input  logic             wr_en_i,
  input  logic [RW-1:0]    wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [RW-1:0]    rd_idx_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             addr_valid_o,
  output logic [DW-1:0]    addr_o,
  output logic             wb_en_o,
  output logic [DW-1:0]    wb_val_o
);
  import agu_pkg::*;

  logic [DW-1:0] base_v, off_reg_v, off_v, addr_d, wb_val_d;
  logic          wb_en_d, accept, commit;
  logic          busy_q, wb_en_q;
  logic [DW-1:0] addr_q, wb_val_q;
  logic [RW-1:0] wb_idx_q;
  logic [1:0]    mode_q;

  assign accept = req_i && !busy_q;
  assign commit = busy_q && done_i;

  agu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .cm_en_i(commit && wb_en_q), .cm_idx_i(wb_idx_q), .cm_data_i(wb_val_q),
    .wr_en_i, .wr_idx_i, .wr_data_i,
    .ra_idx_i(base_sel_i), .ra_data_o(base_v),
    .rb_idx_i(off_sel_i),  .rb_data_o(off_reg_v),
    .rc_idx_i(rd_idx_i),   .rc_data_o(rd_data_o)
  );

  agu_offset #(.DW(DW), .IMM_W(IMM_W), .SH_W(SH_W)) u_off (
    .use_reg_i, .imm_i, .reg_i(off_reg_v), .shamt_i, .shtype_i, .off_o(off_v)
  );

  agu_calc #(.DW(DW)) u_calc (
    .base_i(base_v), .off_i(off_v), .up_i, .mode_i,
    .addr_o(addr_d), .wb_en_o(wb_en_d), .wb_val_o(wb_val_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      wb_en_q  <= 1'b0;
      addr_q   <= '0;
      wb_val_q <= '0;
      wb_idx_q <= '0;
      mode_q   <= IDX_OFF;
    end else if (accept) begin
      busy_q   <= 1'b1;
      wb_en_q  <= wb_en_d;
      addr_q   <= addr_d;
      wb_val_q <= wb_val_d;
      wb_idx_q <= base_sel_i;
      mode_q   <= mode_i;
    end else if (commit) begin
      busy_q   <= 1'b0;
    end
  end

  assign addr_valid_o = busy_q;
  assign addr_o       = addr_q;
  assign wb_en_o      = wb_en_q;
  assign wb_val_o     = wb_val_q;

  assert_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_q);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_i |=> busy_q && $stable(addr_q) && $stable(wb_val_q) && $stable(wb_en_q));
  assert_off_nowb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (mode_q == IDX_OFF || mode_q == IDX_RSV) |-> !wb_en_q);
  assert_pre_same_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && mode_q == IDX_PRE |-> wb_en_q && wb_val_q == addr_q);
  assert_post_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && mode_q == IDX_POST |-> wb_en_q);
endmodule

// File: tb/tb_agu_top.sv
module tb_agu_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req = 0, use_reg = 0, up = 0, done = 0, wr_en = 0;
  logic [2:0] base_sel = 0, off_sel = 0, wr_idx = 0, rd_idx = 0;
  logic [1:0] mode = 0, shtype = 0;
  logic [11:0] imm = 0;
  logic [4:0] shamt = 0;
  logic [31:0] wr_data = 0, rd_data, addr, wb_val;
  logic addr_valid, wb_en;
  int checks = 0, errors = 0;

  agu_top dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .base_sel_i(base_sel), .off_sel_i(off_sel),
    .mode_i(mode), .use_reg_i(use_reg), .up_i(up), .imm_i(imm), .shamt_i(shamt),
    .shtype_i(shtype), .done_i(done), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .addr_valid_o(addr_valid), .addr_o(addr), .wb_en_o(wb_en), .wb_val_o(wb_val)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [31:0] f_off(input logic ur, input logic [11:0] im,
                                        input logic [31:0] rv, input logic [4:0] sa, input logic [1:0] st);
    logic [31:0] r;
    if (!ur) return {20'd0, im};
    case (st)
      2'd1: r = rv >> sa;
      2'd2: r = $signed(rv) >>> sa;
      default: r = rv << sa;
    endcase
    return r;
  endfunction

  // one complete transfer with checks; tags given by caller context
  task automatic run_op(input logic [2:0] bi, input logic [31:0] bv, input logic [2:0] oi,
                        input logic [31:0] ov, input logic [1:0] md, input logic ur,
                        input logic u, input logic [11:0] im, input logic [4:0] sa,
                        input logic [1:0] st);
    logic [31:0] o, s, ea, nb;
    logic we;
    host_wr(bi, bv);
    host_wr(oi, ov);
    o  = f_off(ur, im, ov, sa, st);
    s  = u ? bv + o : bv - o;
    ea = (md == 2'd2) ? bv : s;
    we = (md == 2'd1) || (md == 2'd2);
    nb = we ? s : bv;
    @(negedge clk);
    req = 1; base_sel = bi; off_sel = oi; mode = md; use_reg = ur; up = u;
    imm = im; shamt = sa; shtype = st; rd_idx = bi;
    @(negedge clk); req = 0;
    chk("R7 addr_valid after request", {31'd0, addr_valid}, 32'd1);
    if (md == 2'd2) chk("R5 post address is base", addr, ea);
    else if (md == 2'd1) chk("R4 pre address", addr, ea);
    else chk("R3 offset address", addr, ea);
    if (ur) chk("R6 shifted offset address", addr, ea);
    else chk("R2 immediate offset address", addr, ea);
    chk("R3 R4 R5 wb_en", {31'd0, wb_en}, {31'd0, we});
    if (we) chk("R4 R5 wb_val", wb_val, s);
    done = 1;
    #1 chk("R7 old base before commit edge", rd_data, bv);
    @(negedge clk); done = 0;
    chk("R7 addr_valid falls on completion", {31'd0, addr_valid}, 32'd0);
    if (md == 2'd0 || md == 2'd3) chk("R3 base unchanged", rd_data, nb);
    else chk("R4 R5 base after writeback", rd_data, nb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rvals [4];
    int n;
    logic [4:0] sams [5];
    rvals[0] = 32'h0000_000C; rvals[1] = 32'h8000_00F0;
    rvals[2] = 32'hFFFF_FF00; rvals[3] = 32'h1234_5678;
    sams[0] = 0; sams[1] = 1; sams[2] = 2; sams[3] = 7; sams[4] = 31;

    // R1 reset state
    #23;
    chk("R1 addr_valid in reset", {31'd0, addr_valid}, 32'd0);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i);
      #1 chk("R1 register zero after reset", rd_data, 32'd0);
    end

    // R10 host write
    host_wr(3'd5, 32'hCAFE_0001);
    rd_idx = 3'd5;
    #1 chk("R10 host write visible", rd_data, 32'hCAFE_0001);

    // directed cases
    run_op(3'd1, 32'h6000, 3'd4, 32'hC, 2'd1, 1, 1, 12'd0, 5'd2, 2'd0);
    chk("R6 R4 lsl2 pre base 0x6030", rd_data, 32'h6030);
    run_op(3'd1, 32'h8000, 3'd4, 32'h0, 2'd2, 0, 1, 12'd4, 5'd0, 2'd0);
    chk("R5 post imm 4 base 0x8004", rd_data, 32'h8004);
    run_op(3'd2, 32'h6000, 3'd4, 32'h0, 2'd0, 0, 0, 12'd8, 5'd0, 2'd0);
    run_op(3'd2, 32'h0000_1000, 3'd4, 32'h0, 2'd1, 0, 1, 12'hFFF, 5'd0, 2'd0);
    chk("R2 imm 4095 added", rd_data, 32'h0000_1FFF);
    // R9 wraparound both ways
    run_op(3'd3, 32'hFFFF_FFFC, 3'd4, 32'h0, 2'd1, 0, 1, 12'd8, 5'd0, 2'd0);
    chk("R9 wrap up", rd_data, 32'h4);
    run_op(3'd3, 32'h0000_0004, 3'd4, 32'h0, 2'd2, 0, 0, 12'd8, 5'd0, 2'd0);
    chk("R9 wrap down", rd_data, 32'hFFFF_FFFC);

    // R8 request while busy is ignored
    host_wr(3'd0, 32'h6000);
    @(negedge clk);
    req = 1; base_sel = 0; mode = 2'd1; use_reg = 0; up = 0; imm = 12'd8; rd_idx = 0;
    @(negedge clk);
    chk("R8 first address", addr, 32'h5FF8);
    up = 1; imm = 12'd100; mode = 2'd2;
    @(negedge clk); req = 0;
    chk("R8 address held", addr, 32'h5FF8);
    chk("R8 wb_val held", wb_val, 32'h5FF8);
    done = 1;
    @(negedge clk); done = 0;
    chk("R8 single commit", rd_data, 32'h5FF8);
    @(negedge clk);
    chk("R8 no second access", {31'd0, addr_valid}, 32'd0);

    // near-exhaustive sweep
    n = 0;
    for (int m = 0; m < 4; m++)
      for (int u = 0; u < 2; u++)
        for (int ur = 0; ur < 2; ur++)
          for (int st = 0; st < (ur ? 4 : 1); st++)
            for (int si = 0; si < (ur ? 5 : 1); si++) begin
              run_op(3'(n % 4), 32'h0000_6000 + 32'(n * 52), 3'(4 + n % 4), rvals[n % 4],
                     2'(m), ur[0], u[0], 12'((n * 397 + 11) % 4096), sams[si], 2'(st));
              n++;
            end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule